// File: doc/BRIEF.md
# Byte-Wide Programmable Read-Only Memory Model

This block is a clocked, synthesizable model of a byte-wide, one-time-writable read-only memory with a 15-bit address. Its behaviour is set by a few control pins. The first is an active-low strobe that acts both as chip enable and as program pulse. The second is an active-low output enable. Two flags complete the set: one says the programming supply is raised, and one says the identification voltage is present on address bit 9. From these pins the block decodes seven modes: read, output disable, standby, program, program-verify, program inhibit and identification. It keeps the programmed contents in an inferable RAM, and it can return a manufacturer code and a device code.

The three-state data bus is split into a data output and a drive-enable output, so the model stays synthesizable. The bus data input is a separate port. The full memory space holds 32768 bytes. The storage that is actually built is set by the parameter `DEPTH_W`, so simulations stay short. Every output is registered. A new pin pattern that is held steady shows up on the outputs after exactly two rising clock edges.

Top module: `eprom_model`

## Requirements
- R1: With the supply flag low, strobe low and output enable low (read), `bus_oe` is 1 and `bus_dout` is the stored byte at the address. Both outputs reflect the inputs sampled two rising edges earlier.
- R2: With the supply flag low, either strobe high or output enable high gives `bus_oe` = 0, whatever the other pins are.
- R3: With the supply flag high, strobe low and output enable high (program), `bus_oe` is 0.
- R4: A program pulse is a run of consecutive cycles in program mode. It commits when the next cycle is program inhibit, provided the run lasted at least `MIN_PULSE` clock cycles. The byte at the address held during the last pulse cycle then becomes its old value ANDed with `bus_din`, so a 1 can never be written back.
- R5: A pulse shorter than `MIN_PULSE` cycles leaves the memory unchanged. So does a pulse that ends by output enable going low or by the supply flag dropping.
- R6: With the supply flag high and output enable low (verify), `bus_oe` is 1 and `bus_dout` is the stored byte at the address, whatever the strobe is. The identification flag has no effect while the supply flag is high.
- R7: With the supply flag high and both strobe and output enable high (inhibit), `bus_oe` is 0.
- R8: In identification mode (supply flag low, identification flag high, both enables low), address bit 0 = 0 returns 0x23 and bit 0 = 1 returns 0xE0. These codes apply only when every address bit other than bits 0 and 9 is 0. Otherwise the mode drives 0x00.
- R9: Every byte reads 0xFF before it is programmed. During reset, and in the cycle after it, `bus_oe` and `bus_dout` are 0.
- R10: Only address bits [DEPTH_W-1:0] select a byte. Addresses that differ only above that bit reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 15 | Byte address |
| bus_din | input | 8 | Data presented to the bus for programming |
| strobe_n | input | 1 | Active-low chip enable, also the program pulse |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply is raised |
| id_hv | input | 1 | Identification voltage present on address bit 9 |
| bus_dout | output | 8 | Data driven onto the bus |
| bus_oe | output | 1 | Bus drive enable (1 = driving, 0 = floating) |

## Verification
On every cycle the assertions check how the drive enable relates to the pin pattern two edges earlier: it floats in standby, disable, program and inhibit, and it drives in read, verify and identification. They also check that a write can only follow a cycle spent in program mode and that the pulse counter stays in its range. The byte values can only be shown by the bench's scenarios: AND-only programming, the pulse-length threshold, pulses aborted by output enable or by the supply, the two identification codes and their address qualification, and aliasing above the built depth. The bench checks each of these against a reference array that it keeps in step with its own stimulus.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_DISABLE = 3'd1,
    MD_READ    = 3'd2,
    MD_IDENT   = 3'd3,
    MD_PROGRAM = 3'd4,
    MD_VERIFY  = 3'd5,
    MD_INHIBIT = 3'd6
  } eprom_mode_e;

  function automatic logic mode_drives(eprom_mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int ID_BIT   = 9,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h23,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'hE0
) (
  input  logic              strobe_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  output eprom_mode_e       mode,
  output logic [DATA_W-1:0] id_code
);

  localparam logic [ADDR_W-1:0] ID_MASK =
    ~((ADDR_W'(1) << ID_BIT) | ADDR_W'(1));

  logic rest_clear;

  always_comb begin
    if (vpp_hi) begin
      if (!oe_n)          mode = MD_VERIFY;
      else if (!strobe_n) mode = MD_PROGRAM;
      else                mode = MD_INHIBIT;
    end else begin
      if (strobe_n)       mode = MD_STANDBY;
      else if (oe_n)      mode = MD_DISABLE;
      else if (id_hv)     mode = MD_IDENT;
      else                mode = MD_READ;
    end
  end

  assign rest_clear = ((addr & ID_MASK) == '0);

  always_comb begin
    if (!rest_clear)   id_code = '0;
    else if (addr[0])  id_code = DEV_CODE;
    else               id_code = MFR_CODE;
  end

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_pkg::*;
#(
  parameter int DEPTH_W   = 10,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 4,
  localparam int CNT_W    = $clog2(MIN_PULSE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  eprom_mode_e        mode,
  input  logic               strobe_n,
  input  logic               oe_n,
  input  logic               vpp_hi,
  input  logic [DEPTH_W-1:0] idx,
  input  logic [DATA_W-1:0]  din,
  input  logic [DATA_W-1:0]  old_byte,
  output logic               wr_en,
  output logic [DEPTH_W-1:0] wr_idx,
  output logic [DATA_W-1:0]  wr_data
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

  logic               in_pulse;
  logic [CNT_W-1:0]   width_cnt;
  logic [DEPTH_W-1:0] lat_idx;
  logic [DATA_W-1:0]  lat_din;
  logic               is_prog;

  assign is_prog = (mode == MD_PROGRAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pulse  <= 1'b0;
      width_cnt <= '0;
      lat_idx   <= '0;
      lat_din   <= '0;
    end else begin
      in_pulse <= is_prog;
      if (is_prog) begin
        lat_idx <= idx;
        lat_din <= din;
        if (!in_pulse)                width_cnt <= CNT_W'(1);
        else if (width_cnt != CNT_MAX) width_cnt <= width_cnt + CNT_W'(1);
      end else begin
        width_cnt <= '0;
      end
    end
  end

  assign wr_en   = in_pulse && (mode == MD_INHIBIT) && (width_cnt >= CNT_MAX);
  assign wr_idx  = lat_idx;
  assign wr_data = old_byte & lat_din;

  AST_WRITE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(!strobe_n && oe_n && vpp_hi) && strobe_n && oe_n && vpp_hi)); // R4

  AST_PULSE_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    width_cnt <= CNT_MAX); // R5

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int DEPTH_W = 10,
  parameter int DATA_W  = 8,
  localparam int DEPTH  = 1 << DEPTH_W
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [DEPTH_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [DEPTH_W-1:0] rd_idx,
  output logic [DATA_W-1:0]  rd_data
);

  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
    rd_data <= cells[rd_idx];
  end

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int DEPTH_W   = 10,
  parameter int MIN_PULSE = 4,
  parameter int ID_BIT    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              strobe_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);

  eprom_mode_e        mode, mode_q;
  logic [DATA_W-1:0]  id_code, id_q;
  logic [DATA_W-1:0]  rd_data;
  logic               wr_en;
  logic [DEPTH_W-1:0] wr_idx;
  logic [DATA_W-1:0]  wr_data;
  logic [DEPTH_W-1:0] cell_idx;
  logic [1:0]         warm_cnt;

  assign cell_idx = addr[DEPTH_W-1:0];

  eprom_mode_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BIT(ID_BIT)
  ) decode_i (
    .strobe_n(strobe_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .id_hv(id_hv),
    .addr(addr), .mode(mode), .id_code(id_code)
  );

  eprom_prog_ctrl #(
    .DEPTH_W(DEPTH_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) prog_i (
    .clk(clk), .rst(rst), .mode(mode), .strobe_n(strobe_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .idx(cell_idx), .din(bus_din), .old_byte(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  eprom_array #(
    .DEPTH_W(DEPTH_W), .DATA_W(DATA_W)
  ) array_i (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(cell_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_STANDBY;
      id_q     <= '0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      mode_q <= mode;
      id_q   <= id_code;
      bus_oe <= mode_drives(mode_q);
      if (mode_q == MD_IDENT)        bus_dout <= id_q;
      else if (mode_drives(mode_q))  bus_dout <= rd_data;
      else                           bus_dout <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst || warm_cnt != 2'd2)
    bus_oe |-> $past(!oe_n, 2)); // R2

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst || warm_cnt != 2'd2)
    $past(!vpp_hi && !strobe_n && !oe_n, 2) |-> bus_oe); // R1

  AST_NORMAL_FLOAT: assert property (@(posedge clk) disable iff (rst || warm_cnt != 2'd2)
    $past(!vpp_hi && (strobe_n || oe_n), 2) |-> !bus_oe); // R2

  AST_PROG_FLOAT: assert property (@(posedge clk) disable iff (rst || warm_cnt != 2'd2)
    $past(vpp_hi && oe_n && !strobe_n, 2) |-> !bus_oe); // R3

  AST_INHIBIT_FLOAT: assert property (@(posedge clk) disable iff (rst || warm_cnt != 2'd2)
    $past(vpp_hi && oe_n && strobe_n, 2) |-> !bus_oe); // R7

  AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (rst || warm_cnt != 2'd2)
    $past(vpp_hi && !oe_n, 2) |-> bus_oe); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!bus_oe && bus_dout == '0)); // R9

endmodule

// File: tb/eprom_model_tb_top.sv
module eprom_model_tb_top;

  localparam int ADDR_W    = 15;
  localparam int DATA_W    = 8;
  localparam int DEPTH_W   = 10;
  localparam int MIN_PULSE = 4;
  localparam int DEPTH     = 1 << DEPTH_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] bus_din = '0;
  logic              strobe_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              vpp_hi = 1'b0;
  logic              id_hv = 1'b0;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DATA_W-1:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  eprom_model #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .MIN_PULSE(MIN_PULSE), .ID_BIT(9)
  ) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .bus_din(bus_din), .strobe_n(strobe_n),
    .oe_n(oe_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  function automatic logic [DATA_W:0] expect_bus(logic s, logic o, logic v, logic h,
                                                 logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rest;
    rest = a & ~(ADDR_W'(1) << 9) & ~ADDR_W'(1);
    if (v) return o ? '0 : {1'b1, ref_mem[a[DEPTH_W-1:0]]};
    if (s || o) return '0;
    if (h) begin
      if (rest != '0) return {1'b1, 8'h00};
      return a[0] ? {1'b1, 8'hE0} : {1'b1, 8'h23};
    end
    return {1'b1, ref_mem[a[DEPTH_W-1:0]]};
  endfunction

  task automatic check(string req, logic [DATA_W:0] act, logic [DATA_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
               req, act[DATA_W], act[DATA_W-1:0], exp[DATA_W], exp[DATA_W-1:0]);
    end
  endtask

  task automatic look(string req, logic s, logic o, logic v, logic h, logic [ADDR_W-1:0] a);
    logic [DATA_W:0] e;
    @(negedge clk);
    strobe_n = s; oe_n = o; vpp_hi = v; id_hv = h; addr = a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = expect_bus(s, o, v, h, a);
    if (!e[DATA_W]) check(req, {bus_oe, 8'h00}, '0);
    else            check(req, {bus_oe, bus_dout}, e);
  endtask

  task automatic pulse(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int len);
    @(negedge clk);
    strobe_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b1; id_hv = 1'b0; addr = a; bus_din = d;
    @(negedge clk);
    strobe_n = 1'b0;
    repeat (len) @(posedge clk);
    #1;
    if (len >= 2) check("R3 program floats", {bus_oe, 8'h00}, '0);
    @(negedge clk);
    strobe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (len >= MIN_PULSE) ref_mem[a[DEPTH_W-1:0]] &= d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    void'($urandom(32'd4217));
    strobe_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset quiet", {bus_oe, bus_dout}, '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 quiet after reset", {bus_oe, bus_dout}, '0);

    look("R9 erased byte", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0005);
    pulse(15'h0005, 8'hA5, MIN_PULSE);
    look("R1 read programmed", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0005);
    pulse(15'h0005, 8'h5F, MIN_PULSE + 2);
    look("R4 AND of programs", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0005);
    pulse(15'h0006, 8'h00, MIN_PULSE - 1);
    look("R5 short pulse", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0006);

    // R5: output enable ends the pulse, no write
    @(negedge clk); strobe_n = 1; oe_n = 1; vpp_hi = 1; addr = 15'h0007; bus_din = 8'h00;
    @(negedge clk); strobe_n = 0;
    repeat (MIN_PULSE + 1) @(negedge clk);
    oe_n = 0; @(negedge clk); @(negedge clk);
    strobe_n = 1; oe_n = 1; @(negedge clk); @(negedge clk);
    look("R5 oe abort", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0007);

    // R5: supply drop ends the pulse, no write
    @(negedge clk); strobe_n = 1; oe_n = 1; vpp_hi = 1; addr = 15'h0008; bus_din = 8'h00;
    @(negedge clk); strobe_n = 0;
    repeat (MIN_PULSE + 1) @(negedge clk);
    vpp_hi = 0; @(negedge clk);
    strobe_n = 1; @(negedge clk);
    vpp_hi = 1; @(negedge clk); @(negedge clk);
    look("R5 supply abort", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0008);

    look("R6 verify strobe high", 1'b1, 1'b0, 1'b1, 1'b1, 15'h0005);
    look("R6 verify strobe low", 1'b0, 1'b0, 1'b1, 1'b0, 15'h0005);
    look("R7 inhibit", 1'b1, 1'b1, 1'b1, 1'b0, 15'h0005);
    look("R2 disable", 1'b0, 1'b1, 1'b0, 1'b0, 15'h0005);
    look("R2 standby", 1'b1, 1'b0, 1'b0, 1'b1, 15'h0005);
    look("R8 maker code", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0200);
    look("R8 device code", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0001);
    look("R8 other bits set", 1'b0, 1'b0, 1'b0, 1'b1, 15'h0010);
    look("R10 alias read", 1'b0, 1'b0, 1'b0, 1'b0, 15'h4005);
    pulse(15'h7C09, 8'h3C, MIN_PULSE);
    look("R10 alias program", 1'b0, 1'b0, 1'b0, 1'b0, 15'h0009);

    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a;
      int op;
      a = ADDR_W'(($urandom & 32'h7C00) | ($urandom % 16));
      op = $urandom % 4;
      if (op == 0) pulse(a, 8'($urandom), 1 + ($urandom % (MIN_PULSE + 2)));
      else if (op == 1) look("R1 random read", 1'b0, 1'b0, 1'b0, 1'b0, a);
      else if (op == 2) look("R6 random verify", 1'($urandom), 1'b0, 1'b1, 1'($urandom), a);
      else begin
        logic [ADDR_W-1:0] ia;
        ia = ($urandom % 3 == 0) ? a : ADDR_W'($urandom % 2);
        look("R8 random pins", 1'($urandom), 1'($urandom), 1'b0, 1'($urandom), ia);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule